// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small word-addressed storage array and applies one indivisible read-modify-write operation at a time on behalf of a single requester. A request names an operation, one or two word addresses, two expected values and two new values or operands. The unit reads the old contents, decides whether to commit, writes back, and then returns the old contents together with a success flag. It offers compare-and-swap, unconditional exchange (usable as test-and-set), fetch-and-add, and a paired compare-and-swap across two addresses.

When tagging is enabled, the top bits of each stored word hold a version counter. The unit maintains this counter itself on every committed write. As a result, a requester holding a stale copy whose payload happens to match still fails its compare. Each request owns the unit from acceptance until its response has been taken, so no other request can observe a half-done update.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and every stored word reads as zero.
- R2: Opcode 2'b00 performs compare-and-swap. The addressed word is compared in full, including any tag bits, with `req_exp_a`. Only on equality is the new value written, and `rsp_ok` shows whether the write took place.
- R3: A compare-and-swap always returns the word held before the operation in `rsp_old_a`. A failing one leaves the word unchanged.
- R4: Opcode 2'b01 performs exchange. It always writes `req_val_a`, returns the previous word and sets `rsp_ok` to 1.
- R5: Opcode 2'b10 performs fetch-and-add. It writes the old payload plus the payload of `req_val_a`, wrapping within the payload width, returns the old word and sets `rsp_ok` to 1.
- R6: Opcode 2'b11 with two different addresses performs a paired compare-and-swap. Both words are written only when both match their expected values; otherwise neither changes. `rsp_old_a` and `rsp_old_b` return both old words, and `rsp_ok` reports the commit.
- R7: Opcode 2'b11 with equal addresses acts as a single compare-and-swap using `req_exp_a` and `req_val_a`. In that case `rsp_old_b` equals `rsp_old_a`. For opcodes other than 2'b11, `rsp_old_b` is zero.
- R8: With tagging on, the top TAG_W bits of a word (bits 31:28 at the defaults) are the word's version counter. Every committed write increments the counter, wrapping modulo 2^TAG_W, and the tag bits of supplied values are ignored. A compare whose payload matches but whose tag is older therefore fails.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the response is taken. `rsp_valid` rises on the second edge after acceptance (one read cycle, then one write cycle).
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and unchanged. The edge on which both are 1 ends it, and `req_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op | input | 2 | Operation code |
| req_addr_a | input | ADDR_W | First word address |
| req_addr_b | input | ADDR_W | Second word address (paired compare only) |
| req_exp_a | input | DATA_W | Expected value for first word |
| req_exp_b | input | DATA_W | Expected value for second word |
| req_val_a | input | DATA_W | New value or addend for first word |
| req_val_b | input | DATA_W | New value for second word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_old_a | output | DATA_W | Prior content of first word |
| rsp_old_b | output | DATA_W | Prior content of second word, or zero |
| rsp_ok | output | 1 | Commit / success flag |

## Verification
Every address is visited with every operation under four address and expectation patterns: the same address with a matching compare, a neighbour with the first compare spoiled, a distinct pair with both compares matching, and a distinct pair with only the second compare spoiled. These patterns separate the commit-both, commit-neither and single-location paths of the paired compare. Repeated exchanges on one word drive its version counter through a wrap. A rewrite with an identical payload followed by a compare against the stale copy shows that the tag, not the payload, decides the outcome. A fetch-and-add near the payload maximum checks that the sum wraps without disturbing the tag. Responses are held for varying numbers of cycles to check their stability and the cycle in which they appear.

// File: rtl/armw_pkg.sv
package armw_pkg;

  typedef enum logic [1:0] {
    OP_CAS  = 2'b00,
    OP_XCHG = 2'b01,
    OP_FADD = 2'b10,
    OP_DCAS = 2'b11
  } armw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_READ  = 2'b01,
    ST_WRITE = 2'b10,
    ST_RESP  = 2'b11
  } armw_state_e;

endpackage

// File: rtl/armw_store.sv
module armw_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] wa_a,
  input  logic [DATA_W-1:0] wd_a,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] wa_b,
  input  logic [DATA_W-1:0] wd_b
);

  logic [DATA_W-1:0] words [DEPTH];

  // port a has priority; the controller never writes both ports to one word
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        words[i] <= '0;
      end else if (we_a && (wa_a == ADDR_W'(i))) begin
        words[i] <= wd_a;
      end else if (we_b && (wa_b == ADDR_W'(i))) begin
        words[i] <= wd_b;
      end
    end
  end

  assign rd_data_a = words[rd_addr_a];
  assign rd_data_b = words[rd_addr_b];

endmodule

// File: rtl/armw_alu.sv
module armw_alu
  import armw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit TAG_EN = 1'b1,
  parameter int TAG_W  = 4
) (
  input  armw_op_e          op,
  input  logic              same_addr,
  input  logic [DATA_W-1:0] old_a,
  input  logic [DATA_W-1:0] old_b,
  input  logic [DATA_W-1:0] exp_a,
  input  logic [DATA_W-1:0] exp_b,
  input  logic [DATA_W-1:0] val_a,
  input  logic [DATA_W-1:0] val_b,
  output logic              match_a,
  output logic              match_b,
  output logic              commit_ok,
  output logic              need_wr_a,
  output logic              need_wr_b,
  output logic [DATA_W-1:0] wdata_a,
  output logic [DATA_W-1:0] wdata_b
);

  localparam int PAY_W = TAG_EN ? (DATA_W - TAG_W) : DATA_W;
  localparam logic [DATA_W-1:0] PAY_MASK = {DATA_W{1'b1}} >> (DATA_W - PAY_W);
  localparam logic [DATA_W-1:0] TAG_STEP =
    TAG_EN ? ({{(DATA_W-1){1'b0}}, 1'b1} << PAY_W) : '0;

  // tag field advanced by one (carry out of the word drops = wrap), payload replaced
  function automatic logic [DATA_W-1:0] restamp(input logic [DATA_W-1:0] prev,
                                                input logic [DATA_W-1:0] payload);
    logic [DATA_W-1:0] tag_next;
    tag_next = ((prev & ~PAY_MASK) + TAG_STEP) & ~PAY_MASK;
    return tag_next | (payload & PAY_MASK);
  endfunction

  // payload-only sum; the tag field never sees the carry
  function automatic logic [DATA_W-1:0] payload_sum(input logic [DATA_W-1:0] prev,
                                                    input logic [DATA_W-1:0] opnd);
    return (prev + opnd) & PAY_MASK;
  endfunction

  assign match_a = (old_a == exp_a);
  assign match_b = (old_b == exp_b);
  assign wdata_b = restamp(old_b, val_b);

  always_comb begin
    commit_ok = 1'b0;
    need_wr_a = 1'b0;
    need_wr_b = 1'b0;
    wdata_a   = restamp(old_a, val_a);
    case (op)
      OP_CAS: begin
        commit_ok = match_a;
        need_wr_a = match_a;
      end
      OP_XCHG: begin
        commit_ok = 1'b1;
        need_wr_a = 1'b1;
      end
      OP_FADD: begin
        commit_ok = 1'b1;
        need_wr_a = 1'b1;
        wdata_a   = restamp(old_a, payload_sum(old_a, val_a));
      end
      default: begin
        if (same_addr) begin
          commit_ok = match_a;
          need_wr_a = match_a;
        end else begin
          commit_ok = match_a && match_b;
          need_wr_a = match_a && match_b;
          need_wr_b = match_a && match_b;
        end
      end
    endcase
  end

endmodule

// File: rtl/armw_ctrl.sv
module armw_ctrl
  import armw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic take_req,
  output logic read_phase,
  output logic write_phase,
  output logic rsp_valid,
  output logic rsp_done
);

  armw_state_e state_q, state_d;

  assign req_ready   = (state_q == ST_IDLE);
  assign read_phase  = (state_q == ST_READ);
  assign write_phase = (state_q == ST_WRITE);
  assign rsp_valid   = (state_q == ST_RESP);
  assign take_req    = req_valid && req_ready;
  assign rsp_done    = rsp_valid && rsp_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (take_req) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_RESP;
      default:  if (rsp_done) state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import armw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter bit TAG_EN = 1'b1,
  parameter int TAG_W  = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr_a,
  input  logic [ADDR_W-1:0] req_addr_b,
  input  logic [DATA_W-1:0] req_exp_a,
  input  logic [DATA_W-1:0] req_exp_b,
  input  logic [DATA_W-1:0] req_val_a,
  input  logic [DATA_W-1:0] req_val_b,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_old_a,
  output logic [DATA_W-1:0] rsp_old_b,
  output logic              rsp_ok
);

  logic take_req, read_phase, write_phase, rsp_done;
  logic match_a, match_b, commit_ok, need_wr_a, need_wr_b;
  logic we_a, we_b, same_addr;

  armw_op_e          op_q;
  logic [ADDR_W-1:0] addr_a_q, addr_b_q;
  logic [DATA_W-1:0] exp_a_q, exp_b_q, val_a_q, val_b_q;
  logic [DATA_W-1:0] old_a_q, old_b_q;
  logic [DATA_W-1:0] rd_a, rd_b, wdata_a, wdata_b;
  logic [DATA_W-1:0] rsp_old_a_q, rsp_old_b_q;
  logic              rsp_ok_q;

  armw_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_ready  (rsp_ready),
    .req_ready  (req_ready),
    .take_req   (take_req),
    .read_phase (read_phase),
    .write_phase(write_phase),
    .rsp_valid  (rsp_valid),
    .rsp_done   (rsp_done)
  );

  // request fields frozen for the whole operation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= OP_CAS;
      addr_a_q <= '0;
      addr_b_q <= '0;
      exp_a_q  <= '0;
      exp_b_q  <= '0;
      val_a_q  <= '0;
      val_b_q  <= '0;
    end else if (take_req) begin
      op_q     <= armw_op_e'(req_op);
      addr_a_q <= req_addr_a;
      addr_b_q <= req_addr_b;
      exp_a_q  <= req_exp_a;
      exp_b_q  <= req_exp_b;
      val_a_q  <= req_val_a;
      val_b_q  <= req_val_b;
    end
  end

  assign same_addr = (addr_a_q == addr_b_q);

  armw_store #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr_a(addr_a_q),
    .rd_addr_b(addr_b_q),
    .rd_data_a(rd_a),
    .rd_data_b(rd_b),
    .we_a     (we_a),
    .wa_a     (addr_a_q),
    .wd_a     (wdata_a),
    .we_b     (we_b),
    .wa_b     (addr_b_q),
    .wd_b     (wdata_b)
  );

  // read cycle: snapshot both words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      old_a_q <= '0;
      old_b_q <= '0;
    end else if (read_phase) begin
      old_a_q <= rd_a;
      old_b_q <= rd_b;
    end
  end

  armw_alu #(
    .DATA_W(DATA_W),
    .TAG_EN(TAG_EN),
    .TAG_W (TAG_W)
  ) u_alu (
    .op       (op_q),
    .same_addr(same_addr),
    .old_a    (old_a_q),
    .old_b    (old_b_q),
    .exp_a    (exp_a_q),
    .exp_b    (exp_b_q),
    .val_a    (val_a_q),
    .val_b    (val_b_q),
    .match_a  (match_a),
    .match_b  (match_b),
    .commit_ok(commit_ok),
    .need_wr_a(need_wr_a),
    .need_wr_b(need_wr_b),
    .wdata_a  (wdata_a),
    .wdata_b  (wdata_b)
  );

  // write cycle: conditional commit
  assign we_a = write_phase && need_wr_a;
  assign we_b = write_phase && need_wr_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_old_a_q <= '0;
      rsp_old_b_q <= '0;
      rsp_ok_q    <= 1'b0;
    end else if (write_phase) begin
      rsp_old_a_q <= old_a_q;
      rsp_old_b_q <= (op_q == OP_DCAS) ? old_b_q : '0;
      rsp_ok_q    <= commit_ok;
    end
  end

  assign rsp_old_a = rsp_old_a_q;
  assign rsp_old_b = rsp_old_b_q;
  assign rsp_ok    = rsp_ok_q;

endmodule

// File: rtl/armw_checker.sv
module armw_checker
  import armw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_old_a,
  input logic [DATA_W-1:0] rsp_old_b,
  input logic              rsp_ok,
  input logic              write_phase,
  input logic              we_a,
  input logic              we_b,
  input logic              commit_ok,
  input armw_op_e          op_q
);

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9
  AST_RSP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(write_phase)); // R9
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old_a) && $stable(rsp_old_b) && $stable(rsp_ok))); // R10
  AST_WRITE_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a || we_b) |-> write_phase); // R2
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (write_phase && !commit_ok) |-> (!we_a && !we_b)); // R3
  AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we_b |-> we_a); // R6
  AST_UNCOND_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (op_q == OP_XCHG || op_q == OP_FADD)) |-> rsp_ok); // R4

endmodule

bind atomic_rmw_unit armw_checker #(.DATA_W(DATA_W)) u_armw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_old_a  (rsp_old_a),
  .rsp_old_b  (rsp_old_b),
  .rsp_ok     (rsp_ok),
  .write_phase(write_phase),
  .we_a       (we_a),
  .we_b       (we_b),
  .commit_ok  (commit_ok),
  .op_q       (op_q)
);

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int TW = 4;
  localparam int PW = DW - TW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, rsp_valid, rsp_ready, rsp_ok;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr_a, req_addr_b;
  logic [DW-1:0] req_exp_a, req_exp_b, req_val_a, req_val_b, rsp_old_a, rsp_old_b;

  atomic_rmw_unit #(.DATA_W(DW), .DEPTH(DEPTH), .TAG_EN(1'b1), .TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr_a(req_addr_a), .req_addr_b(req_addr_b),
    .req_exp_a(req_exp_a), .req_exp_b(req_exp_b), .req_val_a(req_val_a),
    .req_val_b(req_val_b), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_old_a(rsp_old_a), .rsp_old_b(rsp_old_b), .rsp_ok(rsp_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] model [DEPTH];
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;
  logic [31:0]   seed = 32'h1234_5678;

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // new word: tag one higher than before, supplied payload
  function automatic logic [DW-1:0] bump(input logic [DW-1:0] prev, input logic [PW-1:0] pay);
    return {prev[DW-1:PW] + TW'(1), pay};
  endfunction

  task automatic chk(input bit good, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input int a, input int b,
                        input logic [DW-1:0] ea, input logic [DW-1:0] eb,
                        input logic [DW-1:0] va, input logic [DW-1:0] vb,
                        input int hold, input string req);
    logic [DW-1:0] oa, ob, xb, sa, sb;
    bit xok, so;
    oa = model[a]; ob = model[b]; xb = '0; xok = 1'b1;
    case (op)
      2'b00: begin
        xok = (oa == ea);
        if (xok) model[a] = bump(oa, va[PW-1:0]);
      end
      2'b01: model[a] = bump(oa, va[PW-1:0]);
      2'b10: model[a] = bump(oa, oa[PW-1:0] + va[PW-1:0]);
      default: begin
        xb = (a == b) ? oa : ob;
        if (a == b) begin
          xok = (oa == ea);
          if (xok) model[a] = bump(oa, va[PW-1:0]);
        end else begin
          xok = (oa == ea) && (ob == eb);
          if (xok) begin
            model[a] = bump(oa, va[PW-1:0]);
            model[b] = bump(ob, vb[PW-1:0]);
          end
        end
      end
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr_a = AW'(a); req_addr_b = AW'(b);
    req_exp_a = ea; req_exp_b = eb; req_val_a = va; req_val_b = vb;
    chk(req_ready, "R9 ready while idle", DW'(req_ready), DW'(1));
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !rsp_valid, "R9 busy after accept", DW'({req_ready, rsp_valid}), DW'(0));
    @(negedge clk);
    chk(!rsp_valid, "R9 no response during write cycle", DW'(rsp_valid), DW'(0));
    @(negedge clk);
    chk(rsp_valid && !req_ready, "R9 response after write cycle", DW'({rsp_valid, req_ready}), DW'(2));
    for (int h = 0; h < hold; h++) begin
      sa = rsp_old_a; sb = rsp_old_b; so = rsp_ok;
      @(negedge clk);
      chk(rsp_valid && rsp_old_a == sa && rsp_old_b == sb && rsp_ok == so,
          "R10 response held", rsp_old_a, sa);
    end
    chk(rsp_old_a == oa, {req, " old word a"}, rsp_old_a, oa);
    chk(rsp_old_b == xb, {req, " old word b"}, rsp_old_b, xb);
    chk(rsp_ok == xok, {req, " success flag"}, DW'(rsp_ok), DW'(xok));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R10 handshake frees unit", DW'({rsp_valid, req_ready}), DW'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    string tag;
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0; req_op = 2'b00;
    req_addr_a = '0; req_addr_b = '0; req_exp_a = '0; req_exp_b = '0;
    req_val_a = '0; req_val_b = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 reset handshake state", DW'({req_ready, rsp_valid}), DW'(2));
    rst_n = 1'b1;

    // R1: every word reads zero; matching CAS also exercises R2
    for (int a = 0; a < DEPTH; a++)
      run_op(2'b00, a, a, '0, '0, next_rand(), '0, a % 3, "R1 R2 first CAS on zero word");

    // main sweep: all addresses x all ops x four address/expectation patterns
    for (int a = 0; a < DEPTH; a++) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < 4; k++) begin
          int b;
          logic [DW-1:0] ea, eb;
          b  = (a + k) % DEPTH;
          ea = (k == 1) ? (model[a] ^ 32'h1) : model[a];
          eb = (k == 3) ? (model[b] ^ 32'h10) : model[b];
          case (op)
            0: tag = "R2 R3 CAS";
            1: tag = "R4 XCHG";
            2: tag = "R5 FADD";
            default: tag = (a == b) ? "R7 DCAS same address" : "R6 DCAS pair";
          endcase
          run_op(2'(op), a, b, ea, eb, next_rand(), next_rand(), k % 3, tag);
        end
      end
    end

    // R3: failing CAS reads each word back unchanged
    for (int a = 0; a < DEPTH; a++)
      run_op(2'b00, a, a, model[a] ^ 32'h1, '0, next_rand(), '0, 0, "R3 failing CAS readback");

    // R8: tag counter wraps, supplied tag bits ignored
    for (int i = 0; i < 20; i++)
      run_op(2'b01, 3, 3, '0, '0, next_rand(), '0, 0, "R8 tag wrap via XCHG");
    run_op(2'b00, 3, 3, model[3] ^ 32'h1, '0, '0, '0, 0, "R8 word after wrap");

    // R8: same payload rewritten, stale copy must fail
    w = model[5];
    run_op(2'b01, 5, 5, '0, '0, w, '0, 0, "R8 rewrite same payload");
    run_op(2'b00, 5, 5, w, '0, 32'h0000_1234, '0, 1, "R8 stale tag CAS fails");
    run_op(2'b00, 5, 5, model[5], '0, 32'h0000_1234, '0, 0, "R8 fresh tag CAS succeeds");

    // R5: payload wraps without carrying into tag
    run_op(2'b01, 6, 6, '0, '0, 32'hFFFF_FFFF, '0, 0, "R4 XCHG to payload max");
    run_op(2'b10, 6, 6, '0, '0, 32'h0000_0005, '0, 2, "R5 FADD payload wrap");
    run_op(2'b00, 6, 6, model[6] ^ 32'h1, '0, '0, '0, 0, "R5 word after FADD wrap");

    // R6: distinct-pair DCAS with first mismatch, then both readback
    run_op(2'b11, 0, 7, model[0] ^ 32'h2, model[7], 32'hAAAA_AAAA, 32'h5555_5555, 0, "R6 DCAS first mismatch");
    run_op(2'b11, 0, 7, model[0], model[7], 32'hAAAA_AAAA, 32'h5555_5555, 0, "R6 DCAS both match");
    run_op(2'b00, 7, 7, model[7] ^ 32'h1, '0, '0, '0, 0, "R6 second word after commit");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule